// File: doc/BRIEF.md
# Memory-Ordering Group Dependency Tracker

This block sits beside the dispatch stage of an out-of-order core and sorts memory operations into ordering groups. Each cycle it takes at most one operation, marked as a load, a store or both, and optionally as a barrier. It hands back a group ID, the table slot that holds the group, and a flag that says whether a group was opened. For every new group it records which older groups must make progress first. Some edges are data edges: the successor waits until the predecessor has fully executed. Others are ordering edges: the successor waits only until every member of the predecessor has issued.

A run of loads with no store or barrier between them, and with no member yet issued, shares one group. Every store and every barrier opens a fresh group. A global no-alias input weakens the store/load edges into ordering edges, or drops them. Issue and execute-complete notices arrive per instruction and are addressed by slot. A slot is freed when all of its members have executed, and any "latest group" pointer that named it is then forgotten.

Top module: `mog_tracker`

## Requirements
- R1: After reset, group IDs are handed out from 1 upwards, one per opened group. `disp_new` is 1 exactly when a group is opened, and a returned ID is never 0. New groups take the lowest-numbered free slot.
- R2: A storing operation always opens a group. If a load or load-barrier group is live, the new group depends on the younger of the two: by a data edge, or by an ordering edge when `no_alias` is 1.
- R3: A storing operation depends by a data edge on the latest store-barrier group, whatever `no_alias` is set to. It also depends on the latest store group when that is a different group: by a data edge, or by an ordering edge under `no_alias`.
- R4: A non-barrier pure load joins the latest load group, returning that group's ID with `disp_new` = 0, when all of these hold: no store group is younger than it, no load barrier dominates, none of its members has issued, and it has fewer than MAX_MEMBERS members.
- R5: A pure load opens a group when it is a barrier, when no load group is live, when the latest load-barrier group dominates, when a store group is as young or younger, when the load group has started issuing, or when the load group is full.
- R6: A load that opens a group depends by a data edge on the latest store group, unless `no_alias` is 1, in which case there is no edge. A barrier load also depends by a data edge on the dominating load group. A plain load also depends by a data edge on the latest load-barrier group.
- R7: A group with a data predecessor is not ready until that predecessor has executed all its members. A group with only ordering predecessors becomes ready once every member of each predecessor has issued.
- R8: When every member of a group has executed, its slot is freed (`grp_valid` low), and any latest-group pointer naming it is cleared. A later operation therefore takes no edge from it.
- R9: `disp_ready` is 0 while every slot is in use.
- R10: `grp_ready[i]` is 1 when slot i holds a group that has no pending predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_alias | input | 1 | Global mode: memory operations are assumed not to alias |
| disp_valid | input | 1 | A memory operation is offered this cycle |
| disp_load | input | 1 | The operation reads memory |
| disp_store | input | 1 | The operation writes memory |
| disp_barrier | input | 1 | The operation is a barrier |
| disp_ready | output | 1 | A free slot exists; an offered operation is taken |
| disp_gid | output | GID_W | Group ID given to the offered operation |
| disp_slot | output | SW | Slot of that group |
| disp_new | output | 1 | A new group is opened for the operation |
| issue_valid | input | 1 | One member of a group issues |
| issue_slot | input | SW | Slot of the issuing member's group |
| exec_valid | input | 1 | One member of a group finishes executing |
| exec_slot | input | SW | Slot of the finishing member's group |
| grp_valid | output | NSLOT | Slot holds a live group |
| grp_ready | output | NSLOT | Slot's group has no pending predecessor |

## Verification
The assertions assume that the core issues a member only from a group whose ready flag is high. They also assume that it reports an execute-complete only for a member that issued in an earlier cycle, and that it never names more issues or completions than a group has members. The bench meets these rules by hand. Every issue it drives goes to a slot it has just seen ready, every completion follows its issue by at least one cycle, and it counts members per group itself. Operations are offered only while `disp_ready` is high, except in the case that fills the table and then only watches the stall.

// File: rtl/mog_pkg.sv
package mog_pkg;

    localparam int GID_W = 8;

    typedef logic [GID_W-1:0] gid_t;

    // a is older than or equal to b under modular (serial) comparison
    function automatic logic gid_le(gid_t a, gid_t b);
        gid_t diff;
        diff = b - a;
        return !diff[GID_W-1];
    endfunction

    // next ID, skipping the reserved "no group" value 0 on wrap
    function automatic gid_t gid_next(gid_t a);
        gid_t n;
        n = a + gid_t'(1);
        if (n == '0) n = gid_t'(1);
        return n;
    endfunction

endpackage

// File: rtl/mog_free_pick.sv
module mog_free_pick #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] busy,
    output logic             any_free,
    output logic [SW-1:0]    pick
);
    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                pick     = SW'(i);
            end
        end
    end
endmodule

// File: rtl/mog_order_policy.sv
module mog_order_policy
    import mog_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             op_store,
    input  logic             op_bar,
    input  logic             no_alias,
    input  logic             ld_vld,
    input  logic [SW-1:0]    ld_slot,
    input  gid_t             ld_id,
    input  logic             st_vld,
    input  logic [SW-1:0]    st_slot,
    input  gid_t             st_id,
    input  logic             lb_vld,
    input  logic [SW-1:0]    lb_slot,
    input  gid_t             lb_id,
    input  logic             sb_vld,
    input  logic [SW-1:0]    sb_slot,
    input  logic [NSLOT-1:0] started,
    input  logic [NSLOT-1:0] full,
    output logic             open_new,
    output logic [SW-1:0]    join_slot,
    output logic [NSLOT-1:0] edge_data,
    output logic [NSLOT-1:0] edge_ord
);
    logic          dom_vld;
    logic          dom_is_lb;
    logic [SW-1:0] dom_slot;
    gid_t          dom_id;

    always_comb begin
        dom_vld   = ld_vld || lb_vld;
        dom_is_lb = lb_vld && (!ld_vld || gid_le(ld_id, lb_id));
        dom_slot  = dom_is_lb ? lb_slot : ld_slot;
        dom_id    = dom_is_lb ? lb_id : ld_id;
        join_slot = ld_slot;
        edge_data = '0;
        edge_ord  = '0;
        open_new  = 1'b1;

        if (op_store) begin
            if (dom_vld) begin
                if (no_alias) edge_ord[dom_slot]  = 1'b1;
                else          edge_data[dom_slot] = 1'b1;
            end
            if (sb_vld) edge_data[sb_slot] = 1'b1;
            if (st_vld && !(sb_vld && (sb_slot == st_slot))) begin
                if (no_alias) edge_ord[st_slot]  = 1'b1;
                else          edge_data[st_slot] = 1'b1;
            end
        end else begin
            open_new = op_bar || !dom_vld || dom_is_lb
                     || (st_vld && gid_le(dom_id, st_id))
                     || started[dom_slot] || full[dom_slot];
            if (open_new) begin
                if (!no_alias && st_vld) edge_data[st_slot] = 1'b1;
                if (op_bar) begin
                    if (dom_vld) edge_data[dom_slot] = 1'b1;
                end else if (lb_vld) begin
                    edge_data[lb_slot] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mog_tracker.sv
module mog_tracker
    import mog_pkg::*;
#(
    parameter int NSLOT       = 8,
    parameter int MAX_MEMBERS = 4,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             no_alias,
    input  logic             disp_valid,
    input  logic             disp_load,
    input  logic             disp_store,
    input  logic             disp_barrier,
    output logic             disp_ready,
    output logic [GID_W-1:0] disp_gid,
    output logic [SW-1:0]    disp_slot,
    output logic             disp_new,
    input  logic             issue_valid,
    input  logic [SW-1:0]    issue_slot,
    input  logic             exec_valid,
    input  logic [SW-1:0]    exec_slot,
    output logic [NSLOT-1:0] grp_valid,
    output logic [NSLOT-1:0] grp_ready
);
    localparam int CW = $clog2(MAX_MEMBERS + 1);
    localparam int PW = $clog2(NSLOT) + 1;

    typedef struct packed {
        logic             vld;
        gid_t             id;
        logic [CW-1:0]    n_inst;
        logic [CW-1:0]    n_iss;
        logic [CW-1:0]    n_exe;
        logic [PW-1:0]    pend_ord;
        logic [PW-1:0]    pend_data;
        logic [NSLOT-1:0] succ_ord;
        logic [NSLOT-1:0] succ_data;
    } slot_t;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] slot;
        gid_t          id;
    } latest_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] slots;
        latest_t           ld;
        latest_t           st;
        latest_t           lb;
        latest_t           sb;
        gid_t              next_id;
    } state_t;

    state_t s_q, s_d;

    logic [NSLOT-1:0] iss_hit_d, exe_hit_d, iss_done_d, all_iss_d;
    logic [NSLOT-1:0] exe_free_d, started_d, full_d, busy_d;
    latest_t          ld_d, st_d, lb_d, sb_d;
    logic             any_free_d, open_new_d, accept_d;
    logic [SW-1:0]    pick_d, join_slot_d;
    logic [NSLOT-1:0] pol_data_d, pol_ord_d, e_data_d, e_ord_d;

    function automatic logic [PW-1:0] pop(logic [NSLOT-1:0] v);
        logic [PW-1:0] c;
        c = '0;
        for (int k = 0; k < NSLOT; k++) c = c + PW'(v[k]);
        return c;
    endfunction

    // per-slot events of this cycle
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            iss_hit_d[i]  = issue_valid && (issue_slot == SW'(i));
            exe_hit_d[i]  = exec_valid && (exec_slot == SW'(i));
            iss_done_d[i] = iss_hit_d[i]
                          && ((s_q.slots[i].n_iss + CW'(1)) == s_q.slots[i].n_inst);
            all_iss_d[i]  = (s_q.slots[i].n_iss == s_q.slots[i].n_inst) || iss_done_d[i];
            exe_free_d[i] = exe_hit_d[i]
                          && ((s_q.slots[i].n_exe + CW'(1)) == s_q.slots[i].n_inst);
            started_d[i]  = (s_q.slots[i].n_iss != '0) || iss_hit_d[i];
            full_d[i]     = (s_q.slots[i].n_inst == CW'(MAX_MEMBERS));
            busy_d[i]     = s_q.slots[i].vld;
        end
        // latest pointers with any group freed this cycle already forgotten
        ld_d = s_q.ld; ld_d.vld = s_q.ld.vld && !exe_free_d[s_q.ld.slot];
        st_d = s_q.st; st_d.vld = s_q.st.vld && !exe_free_d[s_q.st.slot];
        lb_d = s_q.lb; lb_d.vld = s_q.lb.vld && !exe_free_d[s_q.lb.slot];
        sb_d = s_q.sb; sb_d.vld = s_q.sb.vld && !exe_free_d[s_q.sb.slot];
    end

    mog_free_pick #(.NSLOT(NSLOT)) u_pick (
        .busy     (busy_d),
        .any_free (any_free_d),
        .pick     (pick_d)
    );

    mog_order_policy #(.NSLOT(NSLOT)) u_policy (
        .op_store  (disp_store),
        .op_bar    (disp_barrier),
        .no_alias  (no_alias),
        .ld_vld    (ld_d.vld),
        .ld_slot   (ld_d.slot),
        .ld_id     (ld_d.id),
        .st_vld    (st_d.vld),
        .st_slot   (st_d.slot),
        .st_id     (st_d.id),
        .lb_vld    (lb_d.vld),
        .lb_slot   (lb_d.slot),
        .lb_id     (lb_d.id),
        .sb_vld    (sb_d.vld),
        .sb_slot   (sb_d.slot),
        .started   (started_d),
        .full      (full_d),
        .open_new  (open_new_d),
        .join_slot (join_slot_d),
        .edge_data (pol_data_d),
        .edge_ord  (pol_ord_d)
    );

    always_comb begin
        logic dec_ord, dec_data;
        accept_d = disp_valid && any_free_d;
        // a data edge subsumes an ordering edge; an already satisfied ordering edge is dropped
        e_data_d = pol_data_d;
        e_ord_d  = pol_ord_d & ~pol_data_d & ~all_iss_d;

        s_d    = s_q;
        s_d.ld = ld_d;
        s_d.st = st_d;
        s_d.lb = lb_d;
        s_d.sb = sb_d;

        for (int i = 0; i < NSLOT; i++) begin
            dec_ord  = 1'b0;
            dec_data = 1'b0;
            for (int j = 0; j < NSLOT; j++) begin
                if (iss_done_d[j] && s_q.slots[j].succ_ord[i])  dec_ord  = 1'b1;
                if (exe_free_d[j] && s_q.slots[j].succ_data[i]) dec_data = 1'b1;
            end
            if (iss_hit_d[i]) s_d.slots[i].n_iss = s_q.slots[i].n_iss + CW'(1);
            if (exe_hit_d[i]) s_d.slots[i].n_exe = s_q.slots[i].n_exe + CW'(1);
            s_d.slots[i].pend_ord  = s_q.slots[i].pend_ord - PW'(dec_ord);
            s_d.slots[i].pend_data = s_q.slots[i].pend_data - PW'(dec_data);
            if (exe_free_d[i]) begin
                s_d.slots[i].vld       = 1'b0;
                s_d.slots[i].succ_ord  = '0;
                s_d.slots[i].succ_data = '0;
            end
        end

        if (accept_d) begin
            if (open_new_d) begin
                s_d.slots[pick_d].vld       = 1'b1;
                s_d.slots[pick_d].id        = s_q.next_id;
                s_d.slots[pick_d].n_inst    = CW'(1);
                s_d.slots[pick_d].n_iss     = '0;
                s_d.slots[pick_d].n_exe     = '0;
                s_d.slots[pick_d].pend_ord  = pop(e_ord_d);
                s_d.slots[pick_d].pend_data = pop(e_data_d);
                s_d.slots[pick_d].succ_ord  = '0;
                s_d.slots[pick_d].succ_data = '0;
                for (int j = 0; j < NSLOT; j++) begin
                    if (e_ord_d[j])  s_d.slots[j].succ_ord[pick_d]  = 1'b1;
                    if (e_data_d[j]) s_d.slots[j].succ_data[pick_d] = 1'b1;
                end
                s_d.next_id = gid_next(s_q.next_id);
                if (disp_store) s_d.st = '{vld: 1'b1, slot: pick_d, id: s_q.next_id};
                if (disp_store && disp_barrier)
                    s_d.sb = '{vld: 1'b1, slot: pick_d, id: s_q.next_id};
                if (disp_load) s_d.ld = '{vld: 1'b1, slot: pick_d, id: s_q.next_id};
                if (disp_load && disp_barrier)
                    s_d.lb = '{vld: 1'b1, slot: pick_d, id: s_q.next_id};
            end else begin
                s_d.slots[join_slot_d].n_inst = s_q.slots[join_slot_d].n_inst + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.next_id <= gid_t'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_ready = any_free_d;
    assign disp_new   = open_new_d;
    assign disp_slot  = open_new_d ? pick_d : join_slot_d;
    assign disp_gid   = open_new_d ? s_q.next_id : s_q.slots[join_slot_d].id;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            grp_valid[i] = s_q.slots[i].vld;
            grp_ready[i] = s_q.slots[i].vld && (s_q.slots[i].pend_ord == '0)
                         && (s_q.slots[i].pend_data == '0);
        end
    end

    // ---------------- assertions ----------------
    p_gid_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |-> (disp_gid != '0));

    p_new_takes_free_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && disp_new) |-> !grp_valid[disp_slot]);

    p_join_unstarted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && !disp_new) |->
            (grp_valid[disp_slot] && (s_q.slots[disp_slot].n_iss == '0)
             && !(issue_valid && issue_slot == disp_slot)));

    p_issue_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> grp_ready[issue_slot]);

    p_exec_after_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (grp_valid[exec_slot]
                        && (s_q.slots[exec_slot].n_exe < s_q.slots[exec_slot].n_iss)));

    p_store_ptr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st.vld |-> grp_valid[s_q.st.slot]);

    p_load_ptr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ld.vld |-> grp_valid[s_q.ld.slot]);

    for (genvar g = 0; g < NSLOT; g++) begin : g_free_chk
        p_free_on_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_valid[g]) |-> $past(exec_valid && (exec_slot == SW'(g))));
    end
endmodule

// File: tb/mog_tracker_tb.sv
`timescale 1ns/1ps
module mog_tracker_tb;
    localparam int NSLOT = 8;
    localparam int SW    = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             no_alias, disp_valid, disp_load, disp_store, disp_barrier;
    logic             disp_ready, disp_new;
    logic [7:0]       disp_gid;
    logic [SW-1:0]    disp_slot;
    logic             issue_valid, exec_valid;
    logic [SW-1:0]    issue_slot, exec_slot;
    logic [NSLOT-1:0] grp_valid, grp_ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mog_tracker #(.NSLOT(NSLOT), .MAX_MEMBERS(4)) u_dut (
        .clk, .rst_n, .no_alias, .disp_valid, .disp_load, .disp_store, .disp_barrier,
        .disp_ready, .disp_gid, .disp_slot, .disp_new, .issue_valid, .issue_slot,
        .exec_valid, .exec_slot, .grp_valid, .grp_ready
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; no_alias = 1'b0; disp_valid = 1'b0; disp_load = 1'b0;
        disp_store = 1'b0; disp_barrier = 1'b0; issue_valid = 1'b0; exec_valid = 1'b0;
        issue_slot = '0; exec_slot = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic disp(input logic ld, input logic st, input logic bar,
                        output int gid, output int slot, output int nw);
        @(negedge clk);
        disp_valid = 1'b1; disp_load = ld; disp_store = st; disp_barrier = bar;
        #1;
        gid = disp_gid; slot = disp_slot; nw = disp_new;
        @(posedge clk); #1;
        disp_valid = 1'b0; disp_load = 1'b0; disp_store = 1'b0; disp_barrier = 1'b0;
    endtask

    task automatic iss(input int s);
        @(negedge clk); issue_valid = 1'b1; issue_slot = SW'(s);
        @(posedge clk); #1; issue_valid = 1'b0;
    endtask

    task automatic exe(input int s);
        @(negedge clk); exec_valid = 1'b1; exec_slot = SW'(s);
        @(posedge clk); #1; exec_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R9 ready after reset", disp_ready, 1);
        chk("R8 no group after reset", grp_valid, 0);
    endtask

    task automatic t_basic_chain();
        int g, s1, s2, s3, sx, n;
        do_reset();
        disp(1, 0, 0, g, s1, n);
        chk("R1 first id", g, 1); chk("R1 first new", n, 1); chk("R1 lowest slot", s1, 0);
        disp(1, 0, 0, g, sx, n);
        chk("R4 join id", g, 1); chk("R4 join flag", n, 0); chk("R4 join slot", sx, s1);
        disp(0, 1, 0, g, s2, n);
        chk("R2 store id", g, 2); chk("R2 store new", n, 1);
        chk("R2 store waits on load", grp_ready[s2], 0);
        disp(1, 0, 0, g, s3, n);
        chk("R5 load after store new", n, 1); chk("R1 third id", g, 3);
        chk("R6 load waits on store", grp_ready[s3], 0);
        chk("R10 first group ready", grp_ready[s1], 1);
        iss(s1); iss(s1);
        chk("R7 data edge holds after issue", grp_ready[s2], 0);
        exe(s1);
        chk("R8 partial exec keeps group", grp_valid[s1], 1);
        chk("R7 data edge holds partial", grp_ready[s2], 0);
        exe(s1);
        chk("R8 group freed", grp_valid[s1], 0);
        chk("R7 data edge released", grp_ready[s2], 1);
        iss(s2); exe(s2);
        chk("R7 load released by store", grp_ready[s3], 1);
    endtask

    task automatic t_no_alias();
        int g, s0, s1, s2, n;
        do_reset();
        no_alias = 1'b1;
        disp(1, 0, 0, g, s0, n);
        disp(0, 1, 0, g, s1, n);
        chk("R2 ordering edge pending", grp_ready[s1], 0);
        disp(1, 0, 0, g, s2, n);
        chk("R5 load after store opens", n, 1);
        chk("R6 no store edge under no_alias", grp_ready[s2], 1);
        iss(s0);
        chk("R7 ordering edge released on issue", grp_ready[s1], 1);
        chk("R7 predecessor still live", grp_valid[s0], 1);
    endtask

    task automatic t_barrier_load();
        int g, s0, s1, s2, n;
        do_reset();
        disp(1, 0, 0, g, s0, n);
        disp(1, 0, 1, g, s1, n);
        chk("R5 barrier load opens", n, 1);
        chk("R6 barrier load waits", grp_ready[s1], 0);
        disp(1, 0, 0, g, s2, n);
        chk("R5 load after barrier opens", n, 1); chk("R1 id after barrier", g, 3);
        chk("R6 load waits on barrier", grp_ready[s2], 0);
        iss(s0); exe(s0);
        chk("R7 barrier released", grp_ready[s1], 1);
        chk("R7 load still held by barrier", grp_ready[s2], 0);
        iss(s1); exe(s1);
        chk("R7 load released", grp_ready[s2], 1);
    endtask

    task automatic t_started();
        int g, s0, s1, n;
        do_reset();
        disp(1, 0, 0, g, s0, n);
        iss(s0);
        disp(1, 0, 0, g, s1, n);
        chk("R5 started group not joined", n, 1);
        chk("R5 started new id", g, 2);
        chk("R10 independent load ready", grp_ready[s1], 1);
    endtask

    task automatic t_store_barrier();
        int g, s0, s1, n;
        do_reset();
        no_alias = 1'b1;
        disp(0, 1, 1, g, s0, n);
        disp(0, 1, 0, g, s1, n);
        chk("R3 store waits on barrier", grp_ready[s1], 0);
        iss(s0);
        chk("R3 barrier edge is data under no_alias", grp_ready[s1], 0);
        exe(s0);
        chk("R3 barrier edge released", grp_ready[s1], 1);
    endtask

    task automatic t_free_clears();
        int g, s0, s1, n;
        do_reset();
        disp(0, 1, 0, g, s0, n);
        iss(s0); exe(s0);
        chk("R8 store freed", grp_valid[s0], 0);
        disp(1, 0, 0, g, s1, n);
        chk("R8 new id after free", g, 2);
        chk("R8 no edge from freed store", grp_ready[s1], 1);
    endtask

    task automatic t_cap();
        int g, s, n;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            disp(1, 0, 0, g, s, n);
            chk("R4 shared id within cap", g, 1);
        end
        disp(1, 0, 0, g, s, n);
        chk("R5 full group not joined", n, 1);
        chk("R5 id after cap", g, 2);
    endtask

    task automatic t_full();
        int g, s, n;
        do_reset();
        for (int k = 0; k < NSLOT; k++) begin
            disp(0, 1, 0, g, s, n);
            chk("R1 store ids in order", g, k + 1);
        end
        @(negedge clk); #1;
        chk("R9 stalled when full", disp_ready, 0);
        chk("R8 all slots live", grp_valid, 8'hFF);
    endtask

    initial begin
        t_reset();
        t_basic_chain();
        t_no_alias();
        t_barrier_load();
        t_started();
        t_store_barrier();
        t_free_clears();
        t_cap();
        t_full();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule